// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave Bridge

This block sits between an 8-bit external processor bus and the register file of a larger chip. The processor reaches two register groups, each through its own active-low chip select. The bridge turns each bus cycle into exactly one single-cycle internal read or write strobe for the selected group. The strobe comes with the register address and, for writes, the data. For reads it drives the returned value onto the bus behind a tri-state enable.

No strap sets the bus format. The bridge watches the address-latch-enable input during the first access after reset and locks one of three formats. If the latch enable has fallen at least once, the format is multiplexed: address then data on the same eight lines, with separate strobes. If the latch enable is held high, the format is demultiplexed with a read/write level plus a data strobe. If it is held low, the format is demultiplexed with separate read and write strobes. Every bus control and data input passes through a two-flop synchroniser, so all timing is counted in core clock cycles.

Top module: `hostbus_bridge`

## Requirements
- R1: During reset and on the first cycle after it, `reg_rd_en`, `reg_wr_en` and `bus_oe` are all zero.
- R2: The format is chosen at the first access after reset. A falling edge on `alat_en` seen before or at that access selects multiplexed. Otherwise `alat_en` high selects level-plus-strobe and `alat_en` low selects separate strobes.
- R3: Once chosen, the format stays fixed until the next reset, whatever `alat_en` does afterwards.
- R4: In the separate-strobe and multiplexed formats, `wstb_n` low with a chip select marks a write and `rstb_n` low with a chip select marks a read.
- R5: In the level-plus-strobe format, `rstb_n` is the active-low data strobe and `wstb_n` is the direction level (1 = read, 0 = write). A low `wstb_n` with the data strobe high performs no access, and a write completes when the data strobe returns high.
- R6: In the multiplexed format, the address is taken from `bus_in` while `alat_en` is high and held after it falls. `addr_in` is ignored.
- R7: In the demultiplexed formats, the address is taken from `addr_in`.
- R8: `cs_main_n` low alone steers the access to bit 0 of `reg_rd_en`/`reg_wr_en`. `cs_ser_n` low alone steers it to bit 1.
- R9: Each access yields exactly one strobe that lasts one clock: a read strobe at the start of the access, a write strobe after it ends.
- R10: The write data is the last value on `bus_in` sampled before the write strobe ends, even if the bus changed earlier in the access.
- R11: For a read, `bus_oe` is high with `bus_out` equal to the selected group's read data no later than the fourth rising clock edge after the strobe goes active. It stays high while the strobe is held and is low again within six clocks of release.
- R12: An access with both chip selects low produces no internal strobe, and `bus_oe` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_main_n | input | 1 | Chip select for the main register group, active low |
| cs_ser_n | input | 1 | Chip select for the serial controller group, active low |
| wstb_n | input | 1 | Write strobe (separate format) or read/write level (level format) |
| rstb_n | input | 1 | Read strobe (separate format) or data strobe (level format) |
| alat_en | input | 1 | Address latch enable; also the format detection input |
| addr_in | input | AW | Register address in the demultiplexed formats |
| bus_in | input | DW | Bus lines as seen by the pad input |
| bus_out | output | DW | Read data driven toward the pads |
| bus_oe | output | 1 | Pad output enable; high only while read data is supplied |
| reg_rd_en | output | NGRP | One-hot single-cycle internal read strobe per group |
| reg_wr_en | output | NGRP | One-hot single-cycle internal write strobe per group |
| reg_addr | output | AW | Register address for the current strobe |
| reg_wdata | output | DW | Write data for the current write strobe |
| rdata_main | input | DW | Read data from the main group at `reg_addr` |
| rdata_ser | input | DW | Read data from the serial group at `reg_addr` |

## Verification
The bench runs three reset phases, one per format, each opened by a format-selecting first access and followed by seeded random reads and writes to both groups. The multiplexed phase drives a deliberately wrong value on `addr_in`, which shows whether the address comes from the latched bus or from the side port. Writes change the bus halfway through the strobe, which separates capture at the trailing edge from capture at the leading edge. Directed cases cover both chip selects at once, a separate-style write attempted in the level format, and toggling the latch enable after the lock to confirm the format stays fixed.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NGRP     = 2;
    localparam int GRP_MAIN = 0;
    localparam int GRP_SER  = 1;

    typedef enum logic [1:0] {
        MODE_SEP = 2'd0,
        MODE_LVL = 2'd1,
        MODE_MUX = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic cs_main_n;
        logic cs_ser_n;
        logic wstb_n;
        logic rstb_n;
        logic ale;
    } ctrl_t;

    localparam logic [4:0] CTRL_IDLE = 5'b11110;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic strobe_t decode_strobes(bus_mode_e m, logic wstb_n, logic rstb_n);
        strobe_t s;
        if (m == MODE_LVL) begin
            s.rd = ~rstb_n & wstb_n;
            s.wr = ~rstb_n & ~wstb_n;
        end else begin
            s.rd = ~rstb_n;
            s.wr = ~wstb_n;
        end
        return s;
    endfunction

    function automatic bus_mode_e pick_mode(logic fell, logic ale_lvl);
        if (fell)         return MODE_MUX;
        else if (ale_lvl) return MODE_LVL;
        else              return MODE_SEP;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/hb_mode_detect.sv
module hb_mode_detect
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ale_lvl,
    input  logic      acc_start,
    output bus_mode_e mode
);
    logic      ale_d;
    logic      fall_seen;
    logic      locked_q;
    bus_mode_e mode_q;
    bus_mode_e cand;
    logic      ale_fall;

    always_comb begin
        ale_fall = ale_d & ~ale_lvl;
        cand     = pick_mode(fall_seen | ale_fall, ale_lvl);
        mode     = locked_q ? mode_q : cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d     <= 1'b0;
            fall_seen <= 1'b0;
            locked_q  <= 1'b0;
            mode_q    <= MODE_SEP;
        end else begin
            ale_d <= ale_lvl;
            if (!locked_q) begin
                if (ale_fall) fall_seen <= 1'b1;
                if (acc_start) begin
                    locked_q <= 1'b1;
                    mode_q   <= cand;
                end
            end
        end
    end

    // R3: once locked, the chosen format never changes until reset
    assert_mode_lock_R3: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> (locked_q && mode_q == $past(mode_q)));
endmodule

// File: rtl/hb_access.sv
module hb_access
    import hb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_mode_e       mode,
    input  logic            cs_main,
    input  logic            cs_ser,
    input  logic            wstb_n,
    input  logic            rstb_n,
    input  logic [AW-1:0]   addr_cur,
    input  logic [DW-1:0]   data_cur,
    input  logic [DW-1:0]   rdata [NGRP],
    output logic            acc_start,
    output logic [NGRP-1:0] rd_en,
    output logic [NGRP-1:0] wr_en,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    output logic [DW-1:0]   rdata_o,
    output logic            oe_o
);
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

    strobe_t         stb;
    logic            cs_any, cs_valid;
    logic            rd_act, wr_act, rd_prev, wr_prev;
    logic            rd_start, wr_start, wr_end;
    logic [GW-1:0]   grp_now, h_grp, rd_grp_q;
    logic [AW-1:0]   h_addr, addr_q;
    logic [DW-1:0]   h_data, wdata_q, rdata_q;
    logic            h_bad, oe_q;
    logic [NGRP-1:0] rd_hit, wr_hit, rd_q, wr_q;

    always_comb begin
        stb       = decode_strobes(mode, wstb_n, rstb_n);
        cs_any    = cs_main | cs_ser;
        cs_valid  = cs_main ^ cs_ser;
        rd_act    = cs_any & stb.rd;
        wr_act    = cs_any & stb.wr;
        rd_start  = rd_act & ~rd_prev;
        wr_start  = wr_act & ~wr_prev;
        wr_end    = ~wr_act & wr_prev;
        acc_start = rd_start | wr_start;
        grp_now   = cs_ser ? GW'(GRP_SER) : GW'(GRP_MAIN);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign rd_hit[g] = rd_start && cs_valid && (grp_now == GW'(g));
        assign wr_hit[g] = wr_end && !h_bad && (h_grp == GW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev  <= 1'b0;
            wr_prev  <= 1'b0;
            rd_q     <= '0;
            wr_q     <= '0;
            h_addr   <= '0;
            h_data   <= '0;
            h_grp    <= '0;
            h_bad    <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rd_grp_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
            rd_q    <= rd_hit;
            wr_q    <= wr_hit;
            if (wr_act) begin
                h_addr <= addr_cur;
                h_data <= data_cur;
                h_grp  <= grp_now;
                h_bad  <= wr_start ? !cs_valid : (h_bad || !cs_valid);
            end
            if (|rd_hit) begin
                addr_q   <= addr_cur;
                rd_grp_q <= grp_now;
            end
            if (|wr_hit) begin
                addr_q  <= h_addr;
                wdata_q <= h_data;
            end
            if (|rd_q) rdata_q <= rdata[rd_grp_q];
            oe_q <= rd_act && cs_valid && (oe_q || (|rd_q));
        end
    end

    assign rd_en   = rd_q;
    assign wr_en   = wr_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;
    assign oe_o    = oe_q;

    // R9: every internal strobe lasts a single cycle
    assert_rd_single_R9: assert property (@(posedge clk) disable iff (rst)
        (|rd_q) |=> (rd_q == '0));
    assert_wr_single_R9: assert property (@(posedge clk) disable iff (rst)
        (|wr_q) |=> (wr_q == '0));
    // R8: at most one group is strobed at a time
    assert_rd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_q));
    assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_q));
    // R12: the bus is only driven after a cycle with a single chip select
    assert_oe_single_cs_R12: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> $past(cs_valid));
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
    import hb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_main_n,
    input  logic            cs_ser_n,
    input  logic            wstb_n,
    input  logic            rstb_n,
    input  logic            alat_en,
    input  logic [AW-1:0]   addr_in,
    input  logic [DW-1:0]   bus_in,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    output logic [NGRP-1:0] reg_rd_en,
    output logic [NGRP-1:0] reg_wr_en,
    output logic [AW-1:0]   reg_addr,
    output logic [DW-1:0]   reg_wdata,
    input  logic [DW-1:0]   rdata_main,
    input  logic [DW-1:0]   rdata_ser
);
    localparam int CW = $bits(ctrl_t);

    logic [CW-1:0]    ctrl_sv;
    ctrl_t            ctrl_s;
    logic [AW+DW-1:0] data_sv;
    logic [AW-1:0]    addr_s, alat_q, addr_cur;
    logic [DW-1:0]    bus_s;
    logic [DW-1:0]    rdata_arr [NGRP];
    bus_mode_e        mode;
    logic             acc_start;
    logic             rst_seen;

    hb_sync #(.W(CW), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk (clk),
        .rst (rst),
        .d   ({cs_main_n, cs_ser_n, wstb_n, rstb_n, alat_en}),
        .q   (ctrl_sv)
    );

    hb_sync #(.W(AW + DW), .RST_VAL('0)) u_sync_data (
        .clk (clk),
        .rst (rst),
        .d   ({addr_in, bus_in}),
        .q   (data_sv)
    );

    assign ctrl_s           = ctrl_t'(ctrl_sv);
    assign {addr_s, bus_s}  = data_sv;
    assign rdata_arr[GRP_MAIN] = rdata_main;
    assign rdata_arr[GRP_SER]  = rdata_ser;

    // transparent while latch enable is high, holds after it falls
    always_ff @(posedge clk) begin
        if (rst)             alat_q <= '0;
        else if (ctrl_s.ale) alat_q <= AW'(bus_s);
    end

    assign addr_cur = (mode == MODE_MUX) ? alat_q : addr_s;

    hb_mode_detect u_mode (
        .clk       (clk),
        .rst       (rst),
        .ale_lvl   (ctrl_s.ale),
        .acc_start (acc_start),
        .mode      (mode)
    );

    hb_access #(.DW(DW), .AW(AW)) u_access (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cs_main   (~ctrl_s.cs_main_n),
        .cs_ser    (~ctrl_s.cs_ser_n),
        .wstb_n    (ctrl_s.wstb_n),
        .rstb_n    (ctrl_s.rstb_n),
        .addr_cur  (addr_cur),
        .data_cur  (bus_s),
        .rdata     (rdata_arr),
        .acc_start (acc_start),
        .rd_en     (reg_rd_en),
        .wr_en     (reg_wr_en),
        .addr_o    (reg_addr),
        .wdata_o   (reg_wdata),
        .rdata_o   (bus_out),
        .oe_o      (bus_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) rst_seen <= 1'b1;
    end

    // R1: outputs quiet right after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        (rst_seen && $past(rst)) |-> (reg_rd_en == '0 && reg_wr_en == '0 && !bus_oe));
endmodule

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
    localparam int CLK_P  = 10;
    localparam int ST_SEP = 0;
    localparam int ST_LVL = 1;
    localparam int ST_MUX = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_main_n = 1'b1, cs_ser_n = 1'b1, wstb_n = 1'b1, rstb_n = 1'b1, alat_en = 1'b0;
    logic [7:0] addr_in = '0, bus_in = '0;
    logic [7:0] bus_out, reg_addr, reg_wdata, rdata_main, rdata_ser;
    logic       bus_oe;
    logic [1:0] reg_rd_en, reg_wr_en;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, wide = 0;
    logic [7:0] last_wa, last_wd, last_ra;
    int last_wg, last_rg;
    logic prev_w = 1'b0, prev_r = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hostbus_bridge u_dut (
        .clk(clk), .rst(rst), .cs_main_n(cs_main_n), .cs_ser_n(cs_ser_n),
        .wstb_n(wstb_n), .rstb_n(rstb_n), .alat_en(alat_en), .addr_in(addr_in),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rdata_main(rdata_main), .rdata_ser(rdata_ser)
    );

    function automatic logic [7:0] model_rd(int grp, logic [7:0] a);
        return (grp == 1) ? a + 8'h33 : a ^ 8'h5A;
    endfunction

    assign rdata_main = model_rd(0, reg_addr);
    assign rdata_ser  = model_rd(1, reg_addr);

    always @(negedge clk) begin
        if (|reg_wr_en) begin
            wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; last_wg = reg_wr_en[1] ? 1 : 0;
        end
        if (|reg_rd_en) begin
            rd_cnt++; last_ra = reg_addr; last_rg = reg_rd_en[1] ? 1 : 0;
        end
        if (((|reg_wr_en) && prev_w) || ((|reg_rd_en) && prev_r)) wide++;
        prev_w = |reg_wr_en;
        prev_r = |reg_rd_en;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ale_lvl);
        @(negedge clk);
        rst = 1'b1; cs_main_n = 1'b1; cs_ser_n = 1'b1; wstb_n = 1'b1; rstb_n = 1'b1;
        alat_en = ale_lvl;
        idle(1);
        chk(reg_rd_en == 2'b00 && reg_wr_en == 2'b00 && !bus_oe, "R1",
            {reg_rd_en, reg_wr_en, bus_oe}, 0);
        idle(3);
        rst = 1'b0;
        idle(1);
        chk(reg_rd_en == 2'b00 && reg_wr_en == 2'b00 && !bus_oe, "R1",
            {reg_rd_en, reg_wr_en, bus_oe}, 0);
        idle(3);
    endtask

    // cs_sel: 0 main, 1 serial, 2 both
    task automatic access(input int style, input bit is_wr, input int cs_sel,
                          input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input string req);
        int rc0 = rd_cnt;
        int wc0 = wr_cnt;
        logic [7:0] exp;
        if (style == ST_MUX) begin
            bus_in = a; addr_in = ~a; alat_en = 1'b1;
            idle(3);
            alat_en = 1'b0;
            idle(2);
        end else begin
            addr_in = a;
        end
        bus_in    = d0;
        cs_main_n = !(cs_sel == 0 || cs_sel == 2);
        cs_ser_n  = !(cs_sel == 1 || cs_sel == 2);
        if (style == ST_LVL) wstb_n = !is_wr;
        idle(1);
        if (style == ST_LVL)  rstb_n = 1'b0;
        else if (is_wr)       wstb_n = 1'b0;
        else                  rstb_n = 1'b0;
        idle(4);
        if (is_wr) begin
            bus_in = d1;
            idle(4);
        end else begin
            exp = model_rd(cs_sel, a);
            if (cs_sel == 2) chk(!bus_oe, "R12", bus_oe, 0);
            else chk(bus_oe && bus_out == exp, "R11", {bus_oe, bus_out}, {1'b1, exp});
            idle(3);
            if (cs_sel != 2) chk(bus_oe && bus_out == exp, "R11", {bus_oe, bus_out}, {1'b1, exp});
        end
        rstb_n = 1'b1; wstb_n = 1'b1;
        idle(1);
        cs_main_n = 1'b1; cs_ser_n = 1'b1;
        idle(6);
        if (!is_wr && cs_sel != 2) chk(!bus_oe, "R11", bus_oe, 0);
        if (cs_sel == 2) begin
            chk(rd_cnt == rc0 && wr_cnt == wc0, "R12", rd_cnt + wr_cnt, rc0 + wc0);
        end else if (is_wr) begin
            chk(wr_cnt == wc0 + 1, req, wr_cnt, wc0 + 1);
            chk(last_wa == a, (style == ST_MUX) ? "R6" : "R7", last_wa, a);
            chk(last_wd == d1, "R10", last_wd, d1);
            chk(last_wg == cs_sel, "R8", last_wg, cs_sel);
        end else begin
            chk(rd_cnt == rc0 + 1, req, rd_cnt, rc0 + 1);
            chk(last_ra == a, (style == ST_MUX) ? "R6" : "R7", last_ra, a);
            chk(last_rg == cs_sel, "R8", last_rg, cs_sel);
        end
    endtask

    task automatic random_run(input int style, input int n);
        for (int i = 0; i < n; i++) begin
            bit         w  = 1'($urandom);
            int         cs = int'($urandom % 2);
            logic [7:0] a  = 8'($urandom);
            logic [7:0] d0 = 8'($urandom);
            logic [7:0] d1 = d0 ^ 8'($urandom | 1);
            access(style, w, cs, a, d0, d1, (style == ST_LVL) ? "R5" : "R4");
        end
    endtask

    initial begin
        int wc0;
        void'($urandom(32'h0BAD_5EED));

        // separate-strobe format
        do_reset(1'b0);
        access(ST_SEP, 1'b1, 0, 8'h21, 8'hAA, 8'h55, "R2");
        access(ST_SEP, 1'b0, 1, 8'h7F, 8'h00, 8'h00, "R4");
        random_run(ST_SEP, 12);
        access(ST_SEP, 1'b1, 2, 8'h10, 8'h11, 8'h12, "R12");
        access(ST_SEP, 1'b0, 2, 8'h10, 8'h11, 8'h12, "R12");
        alat_en = 1'b1; idle(4);
        access(ST_SEP, 1'b1, 1, 8'h3C, 8'h01, 8'hC3, "R3");
        bus_in = 8'hEE;
        for (int k = 0; k < 3; k++) begin
            alat_en = 1'b1; idle(3); alat_en = 1'b0; idle(3);
        end
        access(ST_SEP, 1'b0, 0, 8'h44, 8'h00, 8'h00, "R3");

        // level-plus-strobe format
        do_reset(1'b1);
        access(ST_LVL, 1'b0, 1, 8'h90, 8'h00, 8'h00, "R2");
        access(ST_LVL, 1'b1, 0, 8'h05, 8'h0F, 8'hF0, "R5");
        wc0 = wr_cnt;
        addr_in = 8'h66; bus_in = 8'h77;
        cs_main_n = 1'b0; wstb_n = 1'b0; rstb_n = 1'b1;
        idle(8);
        wstb_n = 1'b1; idle(1); cs_main_n = 1'b1; idle(6);
        chk(wr_cnt == wc0 && rd_cnt >= 0, "R5", wr_cnt, wc0);
        random_run(ST_LVL, 12);

        // multiplexed format
        do_reset(1'b0);
        access(ST_MUX, 1'b1, 1, 8'hB4, 8'h99, 8'h4B, "R2");
        access(ST_MUX, 1'b0, 0, 8'hC8, 8'h00, 8'h00, "R6");
        random_run(ST_MUX, 12);
        access(ST_MUX, 1'b0, 2, 8'h01, 8'h00, 8'h00, "R12");

        chk(wide == 0, "R9", wide, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule